// File: doc/BRIEF.md
# Machine-mode CSR and trap unit

This unit keeps the machine-level control and status registers of a 32-bit RISC-V hart that runs only in machine mode. Each cycle it can serve one CSR instruction (read, write, set bits or clear bits) addressed by a 12-bit index. It returns the old register value at once and applies the legal form of the new value at the next clock edge. Every index has a defined value: registers that are not implemented, and all user-level and supervisor-level registers, read as zero and ignore writes.

The same unit takes synchronous exceptions and the `mret` return. When one or more exception flags are raised, the unit records the faulting PC, the cause code and the trap value. It also saves the interrupt-enable bit into its previous-enable slot. The pipeline fetches from `trap_pc`, the handler base taken from the trap-vector register. On `mret` the enable bits are restored, and `ret_pc` gives the saved exception PC to resume at.

All outputs are combinational functions of the current inputs and register state. All register updates happen on the rising clock edge, and reset is asynchronous and active low.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset, index 0x300 reads 0x00001800 (machine previous-privilege field fixed at binary 11, both enable bits 0), 0x301 reads the `MISA_VALUE` parameter (default 0x40000100), and indices 0x305, 0x340, 0x341, 0x342 and 0x343 read 0. `trap_pc` and `ret_pc` are 0.
- R2: Indices 0xF11 to 0xF14 read 0. Any index with bits [9:8] equal to 00 or 01, and any index not implemented by the unit (for example 0x7C0), reads 0. A write to such an index returns `csr_illegal` 0 unless its bits [11:10] are 11, and it leaves the index still reading 0.
- R3: With `csr_en` high, `csr_rdata` shows the current value of the indexed register in the same cycle. `csr_op` selects the update: 00 is a plain read with no write, 01 writes `csr_wdata`, 10 ORs `csr_wdata` into the current value, and 11 clears the bits that are set in `csr_wdata`. The new value is readable from the next cycle.
- R4: With `csr_en` high, an op other than 00 on an index whose bits [11:10] are 11 raises `csr_illegal` in the same cycle and changes no register. A plain read (op 00) of such an index gives `csr_illegal` 0.
- R5: Writes keep only legal values. At 0x305 (trap vector), bits [1:0] read 0. At 0x341 (exception PC), bit 0 reads 0. At 0x300, only bit 3 (enable) and bit 7 (previous enable) can be written; bits [12:11] stay 11 and all other bits stay 0. At 0x304, only bits 3, 7 and 11 are kept. At 0x342 (cause), only bits 31 and [3:0] are kept. Indices 0x301, 0x310 and 0x344 ignore writes, and 0x310 and 0x344 read 0. Indices 0x302 and 0x303 hold all 32 bits.
- R6: `exc_flags` bits are: 0 instruction address misaligned (cause 0), 1 illegal instruction (cause 2), 2 breakpoint (cause 3), 3 environment call (cause 11), 4 load address misaligned (cause 4), 5 store address misaligned (cause 5 is not used; the store cause is 6). On any raised flag the next cycle shows 0x341 = `pc` with bit 0 cleared and 0x342 = the cause code. 0x343 shows `fault_val` for causes 0, 4 and 6, and 0 for the other causes.
- R7: When several flags are raised together, the lowest-numbered flag bit selects the cause.
- R8: On trap entry, 0x300 bit 7 takes the old bit 3 and bit 3 becomes 0.
- R9: On `mret` (with no flag raised), 0x300 bit 3 takes the old bit 7 and bit 7 becomes 1. `ret_pc` always equals the value read at 0x341.
- R10: `trap_pc` always equals the value read at 0x305, which has its low two bits zero.
- R11: If an exception and `mret` occur in the same cycle, the exception wins. If either one occurs together with a CSR write, the CSR write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_en | input | 1 | CSR instruction present this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csr_addr | input | 12 | CSR index |
| csr_wdata | input | 32 | Operand for write, set or clear |
| csr_rdata | output | 32 | Current value of the indexed register |
| csr_illegal | output | 1 | Write attempt to a read-only index |
| exc_flags | input | 6 | Exception cause flags, one bit per cause |
| pc | input | 32 | PC of the instruction taking the exception |
| fault_val | input | 32 | Faulting address for misaligned causes |
| mret | input | 1 | Return from machine trap |
| trap_pc | output | 32 | Trap handler entry address |
| ret_pc | output | 32 | Address to resume at after return |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, six exception flags and the default read-only ISA word. This puts every cause code and its priority order within reach, along with the value read back from the ISA register. The test cases cover flag combinations that collide, traps and returns that land in the same cycle as CSR writes, and a trap paired with a return. In these cases the kept state and the saved PC show which event won.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XLEN    = 32;
    localparam int NUM_EXC = 6;
    localparam int CODE_W  = 4;

    typedef enum logic [1:0] {
        CSR_READ  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_op_e;

    localparam logic [11:0] IDX_STATUS  = 12'h300;
    localparam logic [11:0] IDX_ISA     = 12'h301;
    localparam logic [11:0] IDX_EDELEG  = 12'h302;
    localparam logic [11:0] IDX_IDELEG  = 12'h303;
    localparam logic [11:0] IDX_IENABLE = 12'h304;
    localparam logic [11:0] IDX_TVEC    = 12'h305;
    localparam logic [11:0] IDX_STATUSH = 12'h310;
    localparam logic [11:0] IDX_SCRATCH = 12'h340;
    localparam logic [11:0] IDX_EPC     = 12'h341;
    localparam logic [11:0] IDX_CAUSE   = 12'h342;
    localparam logic [11:0] IDX_TVAL    = 12'h343;
    localparam logic [11:0] IDX_IPEND   = 12'h344;

    typedef struct packed {
        logic              ie;
        logic              pie;
        logic [XLEN-1:0]   edeleg;
        logic [XLEN-1:0]   ideleg;
        logic [2:0]        ien;
        logic [XLEN-3:0]   tvec_base;
        logic [XLEN-1:0]   scratch;
        logic [XLEN-2:0]   epc_hi;
        logic              cause_int;
        logic [CODE_W-1:0] cause_code;
        logic [XLEN-1:0]   tval;
    } csr_state_t;

    function automatic logic [CODE_W-1:0] flag_code(int idx);
        case (idx)
            0:       return 4'd0;
            1:       return 4'd2;
            2:       return 4'd3;
            3:       return 4'd11;
            4:       return 4'd4;
            default: return 4'd6;
        endcase
    endfunction

    function automatic logic flag_has_addr(int idx);
        return (idx == 0) || (idx == 4) || (idx == 5);
    endfunction

endpackage

// File: rtl/mcsr_exc_prio.sv
module mcsr_exc_prio
    import mcsr_pkg::*;
#(
    parameter int N = NUM_EXC
) (
    input  logic [N-1:0]      flags,
    output logic              take,
    output logic [CODE_W-1:0] code,
    output logic              addr_kind
);
    always_comb begin
        take      = |flags;
        code      = '0;
        addr_kind = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) begin
                code      = flag_code(i);
                addr_kind = flag_has_addr(i);
            end
        end
    end
endmodule

// File: rtl/mcsr_rd_mux.sv
module mcsr_rd_mux
    import mcsr_pkg::*;
#(
    parameter logic [XLEN-1:0] MISA_VALUE = 32'h4000_0100
) (
    input  logic [11:0]     idx,
    input  csr_state_t      st,
    output logic [XLEN-1:0] value
);
    always_comb begin
        value = '0;
        unique case (idx)
            IDX_STATUS:  value = {19'b0, 2'b11, 3'b0, st.pie, 3'b0, st.ie, 3'b0};
            IDX_ISA:     value = MISA_VALUE;
            IDX_EDELEG:  value = st.edeleg;
            IDX_IDELEG:  value = st.ideleg;
            IDX_IENABLE: value = {20'b0, st.ien[2], 3'b0, st.ien[1], 3'b0, st.ien[0], 3'b0};
            IDX_TVEC:    value = {st.tvec_base, 2'b00};
            IDX_SCRATCH: value = st.scratch;
            IDX_EPC:     value = {st.epc_hi, 1'b0};
            IDX_CAUSE:   value = {st.cause_int, {(XLEN-1-CODE_W){1'b0}}, st.cause_code};
            IDX_TVAL:    value = st.tval;
            default:     value = '0;
        endcase
    end
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
    import mcsr_pkg::*;
#(
    parameter logic [XLEN-1:0] MISA_VALUE = 32'h4000_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_en,
    input  logic [1:0]          csr_op,
    input  logic [11:0]         csr_addr,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     csr_rdata,
    output logic                csr_illegal,
    input  logic [NUM_EXC-1:0]  exc_flags,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     fault_val,
    input  logic                mret,
    output logic [XLEN-1:0]     trap_pc,
    output logic [XLEN-1:0]     ret_pc
);
    csr_state_t        st_q;
    logic              exc_take;
    logic [CODE_W-1:0] exc_code;
    logic              exc_addr;
    logic [XLEN-1:0]   old_val;
    logic [XLEN-1:0]   new_val;
    logic              wants_write;
    logic              wr_ok;
    csr_op_e           op;
    logic              unused_pc_lsb;

    assign op            = csr_op_e'(csr_op);
    assign unused_pc_lsb = pc[0];

    mcsr_exc_prio #(.N(NUM_EXC)) i_prio (
        .flags     (exc_flags),
        .take      (exc_take),
        .code      (exc_code),
        .addr_kind (exc_addr)
    );

    mcsr_rd_mux #(.MISA_VALUE(MISA_VALUE)) i_rd (
        .idx   (csr_addr),
        .st    (st_q),
        .value (old_val)
    );

    always_comb begin
        unique case (op)
            CSR_WRITE: new_val = csr_wdata;
            CSR_SET:   new_val = old_val | csr_wdata;
            CSR_CLEAR: new_val = old_val & ~csr_wdata;
            default:   new_val = old_val;
        endcase
    end

    assign wants_write = csr_en && (op != CSR_READ);
    assign csr_illegal = wants_write && (csr_addr[11:10] == 2'b11);
    assign wr_ok       = wants_write && !csr_illegal && !exc_take && !mret;
    assign csr_rdata   = old_val;
    assign trap_pc     = {st_q.tvec_base, 2'b00};
    assign ret_pc      = {st_q.epc_hi, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (exc_take) begin
            st_q.epc_hi     <= pc[XLEN-1:1];
            st_q.cause_int  <= 1'b0;
            st_q.cause_code <= exc_code;
            st_q.tval       <= exc_addr ? fault_val : '0;
            st_q.pie        <= st_q.ie;
            st_q.ie         <= 1'b0;
        end else if (mret) begin
            st_q.ie  <= st_q.pie;
            st_q.pie <= 1'b1;
        end else if (wr_ok) begin
            unique case (csr_addr)
                IDX_STATUS: begin
                    st_q.ie  <= new_val[3];
                    st_q.pie <= new_val[7];
                end
                IDX_EDELEG:  st_q.edeleg    <= new_val;
                IDX_IDELEG:  st_q.ideleg    <= new_val;
                IDX_IENABLE: st_q.ien       <= {new_val[11], new_val[7], new_val[3]};
                IDX_TVEC:    st_q.tvec_base <= new_val[XLEN-1:2];
                IDX_SCRATCH: st_q.scratch   <= new_val;
                IDX_EPC:     st_q.epc_hi    <= new_val[XLEN-1:1];
                IDX_CAUSE: begin
                    st_q.cause_int  <= new_val[XLEN-1];
                    st_q.cause_code <= new_val[CODE_W-1:0];
                end
                IDX_TVAL:    st_q.tval      <= new_val;
                default:     ;
            endcase
        end
    end

    // R6: the exception PC is saved with bit 0 cleared
    a_r6_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> ret_pc == {$past(pc[XLEN-1:1]), 1'b0});

    // R8: trap entry moves the enable bit into the previous-enable bit
    a_r8_trap_enable: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (!st_q.ie && st_q.pie == $past(st_q.ie)));

    // R9: return restores the enable bit and sets previous-enable
    a_r9_return_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !exc_take) |=> (st_q.ie == $past(st_q.pie) && st_q.pie));

    // R5 and R10: trap vector write reaches trap_pc with low bits cleared
    a_r5_tvec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && op == CSR_WRITE && csr_addr == IDX_TVEC && !exc_take && !mret)
        |=> trap_pc == {$past(csr_wdata[XLEN-1:2]), 2'b00});

    // R4: an illegal write leaves state untouched
    a_r4_illegal_noeffect: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_illegal && !exc_take && !mret)
        |=> ($stable(st_q.scratch) && $stable(st_q.tvec_base) && $stable(st_q.epc_hi)));
endmodule

// File: tb/test_mcsr_trap_unit.sv
`timescale 1ns/1ps
module test_mcsr_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_en;
    logic [1:0]  csr_op;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic [5:0]  exc_flags;
    logic [31:0] pc;
    logic [31:0] fault_val;
    logic        mret;
    logic [31:0] trap_pc;
    logic [31:0] ret_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    mcsr_trap_unit i_mcsr_trap_unit (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .exc_flags(exc_flags), .pc(pc),
        .fault_val(fault_val), .mret(mret), .trap_pc(trap_pc), .ret_pc(ret_pc)
    );

    // monitor: compares queued expectations against outputs mid-cycle
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int          k;
            logic [31:0] e;
            logic [31:0] a;
            string       t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            case (k)
                0:       a = csr_rdata;
                1:       a = {31'b0, csr_illegal};
                2:       a = trap_pc;
                default: a = ret_pc;
            endcase
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
            end
        end
    end

    task automatic expect_out(int kind, logic [31:0] exp, string tag);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        csr_en = 0; csr_op = 0; csr_addr = 0; csr_wdata = 0;
        exc_flags = 0; pc = 0; fault_val = 0; mret = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        csr_en = 1; csr_op = 2'b00; csr_addr = a;
        expect_out(0, exp, tag);
        expect_out(1, 0, tag);
        tick();
    endtask

    task automatic op(logic [1:0] o, logic [11:0] a, logic [31:0] w,
                      logic [31:0] exp_old, logic exp_ill, string tag);
        csr_en = 1; csr_op = o; csr_addr = a; csr_wdata = w;
        expect_out(0, exp_old, tag);
        expect_out(1, {31'b0, exp_ill}, tag);
        tick();
    endtask

    task automatic trap(logic [5:0] f, logic [31:0] p, logic [31:0] fv);
        exc_flags = f; pc = p; fault_val = fv;
        tick();
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(12'h300, 32'h0000_1800, "R1 status");
        rd(12'h301, 32'h4000_0100, "R1 isa");
        rd(12'h305, 0, "R1 tvec");
        rd(12'h340, 0, "R1 scratch");
        rd(12'h341, 0, "R1 epc");
        rd(12'h342, 0, "R1 cause");
        rd(12'h343, 0, "R1 tval");
        expect_out(2, 0, "R1 trap_pc");
        expect_out(3, 0, "R1 ret_pc");
        tick();

        // R2 zero-reading indices
        rd(12'hF11, 0, "R2 id1");
        rd(12'hF12, 0, "R2 id2");
        rd(12'hF13, 0, "R2 id3");
        rd(12'hF14, 0, "R2 id4");
        op(2'b01, 12'h100, 32'hFFFF_FFFF, 0, 0, "R2 sup write");
        rd(12'h100, 0, "R2 sup read");
        rd(12'h000, 0, "R2 user read");
        op(2'b01, 12'h7C0, 32'h1234_5678, 0, 0, "R2 unimpl write");
        rd(12'h7C0, 0, "R2 unimpl read");

        // R3 operations
        op(2'b01, 12'h340, 32'hA5A5_0F0F, 0, 0, "R3 write old");
        rd(12'h340, 32'hA5A5_0F0F, "R3 write new");
        op(2'b10, 12'h340, 32'h0000_F0F0, 32'hA5A5_0F0F, 0, "R3 set old");
        rd(12'h340, 32'hA5A5_FFFF, "R3 set new");
        op(2'b11, 12'h340, 32'hA5A5_0000, 32'hA5A5_FFFF, 0, "R3 clear old");
        rd(12'h340, 32'h0000_FFFF, "R3 clear new");
        op(2'b00, 12'h340, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, "R3 plain read");
        rd(12'h340, 32'h0000_FFFF, "R3 read no write");

        // R4 read-only protection
        op(2'b01, 12'hF11, 32'h1234, 0, 1, "R4 write ro");
        rd(12'hF11, 0, "R4 read ro");
        op(2'b10, 12'hC00, 32'h1, 0, 1, "R4 set ro");

        // R5 legal values, R10 trap_pc
        op(2'b01, 12'h305, 32'h8000_0103, 0, 0, "R5 tvec write");
        rd(12'h305, 32'h8000_0100, "R5 tvec read");
        expect_out(2, 32'h8000_0100, "R10 trap_pc");
        tick();
        op(2'b01, 12'h341, 32'h0000_1235, 0, 0, "R5 epc write");
        rd(12'h341, 32'h0000_1234, "R5 epc read");
        op(2'b01, 12'h300, 32'hFFFF_FFFF, 32'h0000_1800, 0, "R5 status write");
        rd(12'h300, 32'h0000_1888, "R5 status read");
        op(2'b01, 12'h304, 32'hFFFF_FFFF, 0, 0, "R5 ie write");
        rd(12'h304, 32'h0000_0888, "R5 ie read");
        op(2'b01, 12'h342, 32'hFFFF_FFFF, 0, 0, "R5 cause write");
        rd(12'h342, 32'h8000_000F, "R5 cause read");
        op(2'b01, 12'h301, 0, 32'h4000_0100, 0, "R5 isa write");
        rd(12'h301, 32'h4000_0100, "R5 isa read");
        op(2'b01, 12'h344, 32'hFFFF_FFFF, 0, 0, "R5 ip write");
        rd(12'h344, 0, "R5 ip read");
        op(2'b01, 12'h310, 32'hFFFF_FFFF, 0, 0, "R5 statush write");
        rd(12'h310, 0, "R5 statush read");
        op(2'b01, 12'h302, 32'hDEAD_BEEF, 0, 0, "R5 edeleg write");
        rd(12'h302, 32'hDEAD_BEEF, "R5 edeleg read");
        op(2'b11, 12'h300, 32'h0000_0080, 32'h0000_1888, 0, "R5 status clear");
        rd(12'h300, 32'h0000_1808, "R5 status after clear");

        // R6 and R8 store misaligned trap
        trap(6'b100000, 32'h0000_0205, 32'h0000_1003);
        rd(12'h341, 32'h0000_0204, "R6 epc");
        rd(12'h342, 6, "R6 cause store");
        rd(12'h343, 32'h0000_1003, "R6 tval store");
        rd(12'h300, 32'h0000_1880, "R8 status trap");
        expect_out(3, 32'h0000_0204, "R9 ret_pc follows epc");
        tick();

        // R7 priority
        trap(6'b001110, 32'h0000_0300, 32'h0000_DEAD);
        rd(12'h342, 2, "R7 cause illegal wins");
        rd(12'h343, 0, "R7 tval zero");
        rd(12'h300, 32'h0000_1800, "R8 status second trap");
        trap(6'b001000, 32'h0000_0310, 32'h0000_BEEF);
        rd(12'h342, 11, "R6 cause ecall");
        rd(12'h343, 0, "R6 tval ecall");
        trap(6'b110000, 32'h0000_0400, 32'h0000_0077);
        rd(12'h342, 4, "R7 cause load wins");
        rd(12'h343, 32'h0000_0077, "R6 tval load");
        trap(6'b100101, 32'h0000_0502, 32'h0000_0502);
        rd(12'h342, 0, "R7 cause inst wins");
        rd(12'h343, 32'h0000_0502, "R6 tval inst");
        rd(12'h341, 32'h0000_0502, "R6 epc inst");

        // R9 return
        op(2'b01, 12'h300, 32'h0000_0080, 32'h0000_1800, 0, "R9 set pie");
        mret = 1;
        expect_out(3, 32'h0000_0502, "R9 ret_pc");
        tick();
        rd(12'h300, 32'h0000_1888, "R9 status after mret");
        op(2'b11, 12'h300, 32'h0000_0088, 32'h0000_1888, 0, "R9 clear both");
        mret = 1;
        tick();
        rd(12'h300, 32'h0000_1880, "R9 status pie zero");

        // R11 same-cycle priority
        csr_en = 1; csr_op = 2'b01; csr_addr = 12'h340; csr_wdata = 32'h55;
        trap(6'b000100, 32'h0000_0700, 32'h0);
        rd(12'h340, 32'h0000_FFFF, "R11 write dropped by trap");
        rd(12'h342, 3, "R11 cause brk");
        rd(12'h300, 32'h0000_1800, "R11 status after trap");
        csr_en = 1; csr_op = 2'b01; csr_addr = 12'h340; csr_wdata = 32'h66;
        mret = 1;
        tick();
        rd(12'h340, 32'h0000_FFFF, "R11 write dropped by mret");
        rd(12'h300, 32'h0000_1880, "R11 mret applied");
        mret = 1;
        trap(6'b001000, 32'h0000_0600, 32'h0);
        rd(12'h341, 32'h0000_0600, "R11 trap beats mret epc");
        rd(12'h342, 11, "R11 trap beats mret cause");

        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule